// File: doc/BRIEF.md
# Power-Down Entry/Exit Timing Guard

This block sits beside the command scheduler of a DDR3-class memory controller. It watches each command the controller issues and the clock-enable level the controller drives. From these it decides two things: when clock-enable may be taken low to enter power-down, and which commands may follow once clock-enable returns high.

Each accepted command arms a minimum wait before power-down entry. The length of the wait depends on the command type, the read and write latencies, the write-recovery settings and whether burst-chop-4 is fixed in the mode register. When several commands overlap, the longest remaining wait wins. The block also enforces the minimum time clock-enable must hold each level. After exit it applies two separate delays: one for commands that need no locked DLL and one for commands that do.

A forced-exit request warns the controller shortly before the longest permitted power-down stay runs out. All nanosecond minimums arrive as clock counts that are already rounded up. Latencies and limits are configuration inputs.

Top module: `pd_timing_guard`

## Requirements
- R1: A read command (cmd_type 2, with or without auto-precharge) blocks entry until cfg_rl + 5 clocks after it. Entry with clock-enable low on that edge is allowed; pd_entry_ok is high in the cycle before that edge.
- R2: A write command (cmd_type 3) with cfg_bc4_fixed = 0 blocks entry for cfg_wl + 4 + cfg_twr_ck clocks.
- R3: A write with auto-precharge (cmd_type 4) with cfg_bc4_fixed = 0 blocks entry for cfg_wl + 4 + cfg_wr + 1 clocks.
- R4: With cfg_bc4_fixed = 1, both write delays use cfg_wl + 2 in place of cfg_wl + 4.
- R5: The following commands each block entry for 1 clock: activate (cmd_type 0), precharge single or all (cmd_type 1) and refresh (cmd_type 5). A mode-register set (cmd_type 6) blocks entry for max(1, cfg_tmod) clocks.
- R6: When commands overlap, the entry wait is the latest deadline of all of them. A later command never shortens it.
- R7: Clock-enable must hold each level for max(3, cfg_tcke_ck) clocks. pd_entry_ok (needs clock-enable high) and pd_exit_ok (needs clock-enable low) stay low until the current level has lasted that long.
- R8: After clock-enable rises, cmd_ok returns high max(3, cfg_txp_ck) clocks after the rising edge.
- R9: cmd_dll_ok returns high max(10, cfg_txpdll_ck) clocks after the rising edge when cfg_dll_frozen = 1. When cfg_dll_frozen = 0 it follows the R8 delay.
- R10: While clock-enable is low, force_exit rises once the stay has lasted cfg_pd_max - 1 clocks. The stay is counted from the falling edge. This is one clock before the limit.
- R11: After reset, clock-enable is taken as high and settled, and no wait is pending. pd_entry_ok, cmd_ok and cmd_dll_ok are 1; pd_exit_ok and force_exit are 0.
- R12: cmd_type 7 (no operation) arms no entry wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued on this edge |
| cmd_type | input | 3 | 0 ACT, 1 PRE/PREA, 2 RD/RDA, 3 WR, 4 WRA, 5 REF, 6 MRS, 7 NOP |
| cke | input | 1 | Clock-enable level driven to the memory on this edge |
| cfg_rl | input | LW | Read latency in clocks |
| cfg_wl | input | LW | Write latency in clocks |
| cfg_wr | input | LW | Write recovery setting in clocks |
| cfg_twr_ck | input | CW | Write recovery time, rounded up to clocks |
| cfg_tmod | input | CW | Mode-register-set to next command delay in clocks |
| cfg_tcke_ck | input | CW | Clock-enable pulse time, rounded up to clocks |
| cfg_txp_ck | input | CW | Exit-to-command time, rounded up to clocks |
| cfg_txpdll_ck | input | CW | Exit-to-DLL-command time, rounded up to clocks |
| cfg_bc4_fixed | input | 1 | Burst-chop-4 fixed by mode register |
| cfg_dll_frozen | input | 1 | Precharge power-down keeps the DLL frozen |
| cfg_pd_max | input | PDW | Longest power-down stay in clocks |
| pd_entry_ok | output | 1 | Clock-enable may go low on the next edge |
| pd_exit_ok | output | 1 | Clock-enable may go high on the next edge |
| cmd_ok | output | 1 | A command not needing a locked DLL may issue on the next edge |
| cmd_dll_ok | output | 1 | A command needing a locked DLL may issue on the next edge |
| force_exit | output | 1 | Power-down must end now |

## Verification
Every output is registered one stage after the event that affects it. A command or clock-enable change sampled on edge n first shows in the outputs after edge n. A wait of D clocks turns its flag back on in the cycle after edge n + D - 1. That cycle is the last one before the first legal edge.

The bench keeps absolute edge numbers for:
- the latest entry deadline,
- the last clock-enable change,
- the last exit,
- the last entry.

After every edge it derives all five flags from these numbers and compares them at the falling clock edge. The checks cover each command type, overlapping commands, the fixed burst-chop setting, floor values taking over from small configured times, both DLL exit modes, and a stay long enough to raise the forced exit.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_PRE = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_WRA = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_NOP = 3'd7
    } pdg_cmd_e;

    localparam int TCKE_FLOOR   = 3;
    localparam int TXP_FLOOR    = 3;
    localparam int TXPDLL_FLOOR = 10;
    localparam int RD_EXTRA     = 5;
    localparam int BURST_LONG   = 4;
    localparam int BURST_CHOP   = 2;

endpackage

// File: rtl/pdg_entry_calc.sv
module pdg_entry_calc #(
    parameter int LW = 6,
    parameter int CW = 8
) (
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_type,
    input  logic [LW-1:0] cfg_rl,
    input  logic [LW-1:0] cfg_wl,
    input  logic [LW-1:0] cfg_wr,
    input  logic [CW-1:0] cfg_twr_ck,
    input  logic [CW-1:0] cfg_tmod,
    input  logic          cfg_bc4_fixed,
    output logic          arm,
    output logic [CW-1:0] arm_val
);
    import pdg_pkg::*;

    localparam int SW = CW + 2;
    localparam logic [SW-1:0] SAT = SW'({CW{1'b1}});

    logic [SW-1:0] rl_x, wl_x, wr_x, twr_x, tmod_x, burst_x, sum_d, sat_d;

    always_comb begin
        rl_x    = SW'(cfg_rl);
        wl_x    = SW'(cfg_wl);
        wr_x    = SW'(cfg_wr);
        twr_x   = SW'(cfg_twr_ck);
        tmod_x  = SW'(cfg_tmod);
        burst_x = cfg_bc4_fixed ? SW'(BURST_CHOP) : SW'(BURST_LONG);
        arm     = cmd_valid;
        unique case (pdg_cmd_e'(cmd_type))
            CMD_RD:  sum_d = rl_x + SW'(RD_EXTRA);
            CMD_WR:  sum_d = wl_x + burst_x + twr_x;
            CMD_WRA: sum_d = wl_x + burst_x + wr_x + SW'(1);
            CMD_MRS: sum_d = (tmod_x == '0) ? SW'(1) : tmod_x;
            CMD_NOP: begin
                sum_d = SW'(1);
                arm   = 1'b0;
            end
            default: sum_d = SW'(1);
        endcase
        sat_d   = (sum_d > SAT) ? SAT : sum_d;
        arm_val = CW'(sat_d - SW'(1));
    end

endmodule

// File: rtl/pdg_countdown.sv
module pdg_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q, dec_d;

    always_comb begin
        dec_d = (cnt_q == '0) ? '0 : cnt_q - W'(1);
        cnt_d = (load && load_val > dec_d) ? load_val : dec_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pd_timing_guard.sv
module pd_timing_guard #(
    parameter int LW  = 6,
    parameter int CW  = 8,
    parameter int PDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_type,
    input  logic           cke,
    input  logic [LW-1:0]  cfg_rl,
    input  logic [LW-1:0]  cfg_wl,
    input  logic [LW-1:0]  cfg_wr,
    input  logic [CW-1:0]  cfg_twr_ck,
    input  logic [CW-1:0]  cfg_tmod,
    input  logic [CW-1:0]  cfg_tcke_ck,
    input  logic [CW-1:0]  cfg_txp_ck,
    input  logic [CW-1:0]  cfg_txpdll_ck,
    input  logic           cfg_bc4_fixed,
    input  logic           cfg_dll_frozen,
    input  logic [PDW-1:0] cfg_pd_max,
    output logic           pd_entry_ok,
    output logic           pd_exit_ok,
    output logic           cmd_ok,
    output logic           cmd_dll_ok,
    output logic           force_exit
);
    import pdg_pkg::*;

    typedef struct packed {
        logic           cke;
        logic [CW-1:0]  lvl;
        logic [PDW-1:0] pdc;
    } state_t;

    state_t st_d, st_q;

    logic          ent_arm, ent_zero, xp_zero, xpdll_zero, rise;
    logic [CW-1:0] ent_val, ent_cnt, xp_cnt, xpdll_cnt;
    logic [CW-1:0] tcke_eff, txp_eff, txpdll_eff, xp_val, xpdll_val;
    logic          cke_q;

    pdg_entry_calc #(.LW(LW), .CW(CW)) u_calc (
        .cmd_valid     (cmd_valid),
        .cmd_type      (cmd_type),
        .cfg_rl        (cfg_rl),
        .cfg_wl        (cfg_wl),
        .cfg_wr        (cfg_wr),
        .cfg_twr_ck    (cfg_twr_ck),
        .cfg_tmod      (cfg_tmod),
        .cfg_bc4_fixed (cfg_bc4_fixed),
        .arm           (ent_arm),
        .arm_val       (ent_val)
    );

    pdg_countdown #(.W(CW)) u_ent (
        .clk(clk), .rst_n(rst_n), .load(ent_arm), .load_val(ent_val),
        .cnt(ent_cnt), .zero(ent_zero)
    );

    pdg_countdown #(.W(CW)) u_xp (
        .clk(clk), .rst_n(rst_n), .load(rise), .load_val(xp_val),
        .cnt(xp_cnt), .zero(xp_zero)
    );

    pdg_countdown #(.W(CW)) u_xpdll (
        .clk(clk), .rst_n(rst_n), .load(rise), .load_val(xpdll_val),
        .cnt(xpdll_cnt), .zero(xpdll_zero)
    );

    always_comb begin
        tcke_eff   = (cfg_tcke_ck   < CW'(TCKE_FLOOR))   ? CW'(TCKE_FLOOR)   : cfg_tcke_ck;
        txp_eff    = (cfg_txp_ck    < CW'(TXP_FLOOR))    ? CW'(TXP_FLOOR)    : cfg_txp_ck;
        txpdll_eff = (cfg_txpdll_ck < CW'(TXPDLL_FLOOR)) ? CW'(TXPDLL_FLOOR) : cfg_txpdll_ck;
        xp_val     = txp_eff - CW'(1);
        xpdll_val  = (cfg_dll_frozen ? txpdll_eff : txp_eff) - CW'(1);
        rise       = cke && !st_q.cke;

        st_d     = st_q;
        st_d.cke = cke;
        if (cke != st_q.cke)        st_d.lvl = CW'(1);
        else if (st_q.lvl != '1)    st_d.lvl = st_q.lvl + CW'(1);
        if (cke)                    st_d.pdc = '0;
        else if (st_q.cke)          st_d.pdc = PDW'(1);
        else if (st_q.pdc != '1)    st_d.pdc = st_q.pdc + PDW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cke <= 1'b1;
            st_q.lvl <= '1;
            st_q.pdc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cke_q       = st_q.cke;
    assign pd_entry_ok = st_q.cke && ent_zero && (st_q.lvl >= tcke_eff);
    assign pd_exit_ok  = !st_q.cke && (st_q.lvl >= tcke_eff);
    assign cmd_ok      = st_q.cke && xp_zero;
    assign cmd_dll_ok  = st_q.cke && xpdll_zero;
    assign force_exit  = !st_q.cke &&
                         ({1'b0, st_q.pdc} + (PDW+1)'(1) >= {1'b0, cfg_pd_max});

endmodule

module pdg_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_type,
    input logic          cke,
    input logic          cke_q,
    input logic [CW-1:0] ent_cnt,
    input logic          pd_entry_ok,
    input logic          pd_exit_ok,
    input logic          cmd_ok,
    input logic          cmd_dll_ok,
    input logic          force_exit
);
    // R1
    rd_entry_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 3'd2) |=> !pd_entry_ok);

    // R6
    no_shorten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_cnt != '0) |=> (ent_cnt >= $past(ent_cnt) - CW'(1)));

    // R7
    cke_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != cke_q) |=> (!pd_entry_ok && !pd_exit_ok));

    // R8
    xp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cke_q) |=> !cmd_ok);

    // R9
    xpdll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cke_q) |=> !cmd_dll_ok);

    // R10
    force_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_exit |-> (!cmd_ok && !pd_entry_ok));

endmodule

bind pd_timing_guard pdg_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cke(cke), .cke_q(cke_q), .ent_cnt(ent_cnt),
    .pd_entry_ok(pd_entry_ok), .pd_exit_ok(pd_exit_ok), .cmd_ok(cmd_ok),
    .cmd_dll_ok(cmd_dll_ok), .force_exit(force_exit)
);

// File: tb/tb_pd_timing_guard.sv
module tb_pd_timing_guard;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 6, CW = 8, PDW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cke = 1'b1;
    logic [2:0] cmd_type = 3'd7;
    logic [LW-1:0] cfg_rl = 6'd11, cfg_wl = 6'd8, cfg_wr = 6'd12;
    logic [CW-1:0] cfg_twr_ck = 8'd12, cfg_tmod = 8'd12, cfg_tcke_ck = 8'd4;
    logic [CW-1:0] cfg_txp_ck = 8'd5, cfg_txpdll_ck = 8'd20;
    logic cfg_bc4_fixed = 1'b0, cfg_dll_frozen = 1'b1;
    logic [PDW-1:0] cfg_pd_max = 16'd40;
    logic pd_entry_ok, pd_exit_ok, cmd_ok, cmd_dll_ok, force_exit;

    pd_timing_guard #(.LW(LW), .CW(CW), .PDW(PDW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cke(cke),
        .cfg_rl(cfg_rl), .cfg_wl(cfg_wl), .cfg_wr(cfg_wr), .cfg_twr_ck(cfg_twr_ck),
        .cfg_tmod(cfg_tmod), .cfg_tcke_ck(cfg_tcke_ck), .cfg_txp_ck(cfg_txp_ck),
        .cfg_txpdll_ck(cfg_txpdll_ck), .cfg_bc4_fixed(cfg_bc4_fixed),
        .cfg_dll_frozen(cfg_dll_frozen), .cfg_pd_max(cfg_pd_max),
        .pd_entry_ok(pd_entry_ok), .pd_exit_ok(pd_exit_ok), .cmd_ok(cmd_ok),
        .cmd_dll_ok(cmd_dll_ok), .force_exit(force_exit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int earliest = 0, last_chg = -1000, exit_at = -1000, dll_at = -1000, entry_at = 0;
    logic level = 1'b1;
    logic cur_cke = 1'b1;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int delay_of(logic [2:0] t);
        int burst = cfg_bc4_fixed ? 2 : 4;
        case (t)
            3'd2: return int'(cfg_rl) + 5;
            3'd3: return int'(cfg_wl) + burst + int'(cfg_twr_ck);
            3'd4: return int'(cfg_wl) + burst + int'(cfg_wr) + 1;
            3'd6: return imax(1, int'(cfg_tmod));
            default: return 1;
        endcase
    endfunction

    task automatic cmp(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, name, cyc, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int m = cyc;
        int tck = imax(3, int'(cfg_tcke_ck));
        int txp = imax(3, int'(cfg_txp_ck));
        cmp(tag, "pd_entry_ok", pd_entry_ok, level && (m + 1 >= earliest) && (m + 1 - last_chg >= tck));
        cmp(tag, "pd_exit_ok",  pd_exit_ok,  !level && (m + 1 - last_chg >= tck));
        cmp(tag, "cmd_ok",      cmd_ok,      level && (m + 1 >= exit_at + txp));
        cmp(tag, "cmd_dll_ok",  cmd_dll_ok,  level && (m + 1 >= dll_at));
        cmp(tag, "force_exit",  force_exit,  !level && (m - entry_at + 1 >= int'(cfg_pd_max) - 1));
    endtask

    task automatic step(logic v, logic [2:0] t, string tag);
        int n;
        @(negedge clk);
        check_all(tag);
        n = cyc + 1;
        cmd_valid = v;
        cmd_type  = t;
        cke       = cur_cke;
        if (v && t != 3'd7) earliest = imax(earliest, n + delay_of(t));
        if (cur_cke != level) begin
            last_chg = n;
            if (cur_cke) begin
                exit_at = n;
                dll_at  = n + (cfg_dll_frozen ? imax(10, int'(cfg_txpdll_ck))
                                              : imax(3, int'(cfg_txp_ck)));
            end else begin
                entry_at = n;
            end
            level = cur_cke;
        end
    endtask

    task automatic idle(int k, string tag);
        for (int i = 0; i < k; i++) step(1'b0, 3'd7, tag);
    endtask

    task automatic pd_cycle(int low, int high, string tag);
        cur_cke = 1'b0;
        idle(low, tag);
        cur_cke = 1'b1;
        idle(high, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R11");
        step(1'b1, 3'd0, "R5"); idle(3, "R5");
        step(1'b1, 3'd1, "R5"); idle(2, "R5");
        step(1'b1, 3'd5, "R5"); idle(2, "R5");
        step(1'b1, 3'd6, "R5"); idle(14, "R5");
        step(1'b1, 3'd2, "R1"); idle(18, "R1");
        step(1'b1, 3'd3, "R2"); idle(27, "R2");
        step(1'b1, 3'd4, "R3"); idle(28, "R3");
        cfg_bc4_fixed = 1'b1;
        step(1'b1, 3'd3, "R4"); idle(24, "R4");
        step(1'b1, 3'd4, "R4"); idle(25, "R4");
        cfg_bc4_fixed = 1'b0;
        step(1'b1, 3'd4, "R6");
        step(1'b1, 3'd0, "R6");
        step(1'b1, 3'd2, "R6"); idle(28, "R6");
        step(1'b1, 3'd7, "R12"); idle(3, "R12");
        pd_cycle(1, 6, "R7");
        cfg_dll_frozen = 1'b1;
        pd_cycle(6, 25, "R9");
        cfg_dll_frozen = 1'b0;
        pd_cycle(6, 15, "R8");
        pd_cycle(45, 15, "R10");
        cfg_tcke_ck = 8'd1; cfg_txp_ck = 8'd1; cfg_txpdll_ck = 8'd2;
        idle(5, "R7");
        pd_cycle(5, 15, "R7");
        cfg_dll_frozen = 1'b1;
        pd_cycle(5, 15, "R9");
        idle(2, "R11");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule